// File: doc/BRIEF.md
# Double-Buffered Wavetable Oscillator

This block plays a single-cycle waveform stored as 2048 signed 16-bit samples. A 48-bit phase accumulator advances once per sample strobe. Its eleven most significant bits address the table, so the accumulator only supplies a read index and holds no waveform of its own. The step comes from one of two tuning registers. One is a full-width word for audio-rate pitch. The other is a narrow word for very slow control-rate sweeps, where resolution far below one hertz matters. Both ranges share the same accumulator, and switching between them never resets the phase.

The table has two banks. Playback reads the active bank while a writer loads the other bank through a valid/ready stream. The writer finishes a table and then pulses a swap request. The request is held as pending, and the banks exchange on the strobe whose addition carries out of the accumulator, so the waveform is replaced exactly at a cycle boundary. A new table can therefore be loaded on every playback cycle. While a swap is pending, `wr_ready` stays low, so no write can reach the bank that is about to go live. The writer must hold `wr_valid`, `wr_addr` and `wr_data` until it sees `wr_ready` high; a beat is taken on a clock edge where both are high. The sample output carries only `out_valid` and has no back-pressure: one sample comes out for each strobe and must be consumed in that cycle.

Top module: `wt_osc`

## Requirements
- R1: After reset, `out_valid` is 0, `play_bank` is 0, `wr_ready` is 1, no swap is pending and the phase is 0.
- R2: At each clock edge where `sample_en` is 1, the phase becomes (phase + step) mod 2^48. On the following edge, `out_valid` goes to 1 for one cycle and `out_sample` shows the active-bank word at index phase[47:37], using the phase after that addition.
- R3: With `range_sel` = 0 the step is the 48-bit audio word. With `range_sel` = 1 the step is the 28-bit control word, zero-extended to 48 bits. Changing `range_sel` leaves the phase where it is.
- R4: A cycle with `tw_we` = 1 loads `tw_data` into the audio word when `tw_sel` = 0. When `tw_sel` = 1 it loads `tw_data[27:0]` into the control word and ignores the upper bits. The new word applies from the next strobe onward, and the phase is not disturbed.
- R5: A beat with `wr_valid` and `wr_ready` both 1 stores `wr_data` at `wr_addr` in the bank that is not playing. It never changes the playing bank.
- R6: A `swap_req` pulse sets the pending state. While a swap is pending, `wr_ready` is 0, and a beat offered with `wr_valid` = 1 is dropped and leaves the table unchanged.
- R7: A pending swap takes effect on the strobe edge whose addition carries out of bit 47. `play_bank` toggles, the pending state clears and `wr_ready` returns to 1. The sample produced by that strobe, and every later one, comes from the new bank. A request that arrives on the same edge as the carry waits for the next carry.
- R8: A carry with no swap pending leaves `play_bank` unchanged. A `swap_req` that arrives while a swap is already pending causes no second toggle.
- R9: On edges where `sample_en` is 0, the phase holds. Only strobes produce samples, and `out_valid` is 0 in the cycle after a non-strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Sample strobe; advances the phase |
| range_sel | input | 1 | 0 = audio step word, 1 = control step word |
| tw_we | input | 1 | Tuning word write enable |
| tw_sel | input | 1 | Tuning word target: 0 audio, 1 control |
| tw_data | input | 48 | Tuning word value |
| wr_valid | input | 1 | Table write beat offered |
| wr_ready | output | 1 | Table write beat can be taken (no swap pending) |
| wr_addr | input | 11 | Table write index |
| wr_data | input | 16 | Table write sample |
| swap_req | input | 1 | Request a bank exchange at the next phase wrap |
| out_valid | output | 1 | Output sample present this cycle |
| out_sample | output | 16 | Output sample |
| play_bank | output | 1 | Bank currently being played |

## Verification
The oscillator first runs with a coarse audio step that wraps every 16 strobes and visits every 128th table entry. This exposes errors in index slicing, carry detection and wrap-aligned bank exchange. Other passes cover a mid-run step change with an uneven fractional part, a long run with the full-scale control word, and a return to audio after switching ranges. These show whether the accumulator keeps its phase across word and range changes and whether the narrow word is zero-extended. The swap patterns are a single request, a doubled request and a run of wraps with no request. A write is also offered while a swap is pending, at an index that the next playback pass reads back. Together these separate a correct swap from an early swap, a repeated swap or a lost swap, and catch a leaked write.

// File: rtl/wt_osc_pkg.sv
package wt_osc_pkg;
  localparam int PHASE_W = 48;
  localparam int ADDR_W  = 11;
  localparam int DATA_W  = 16;
  localparam int CTRL_W  = 28;
endpackage

// File: rtl/wt_phase_acc.sv
module wt_phase_acc #(
  parameter int PHASE_W = 48,
  parameter int CTRL_W  = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic               range_sel,
  input  logic               tw_we,
  input  logic               tw_sel,
  input  logic [PHASE_W-1:0] tw_data,
  output logic [PHASE_W-1:0] phase,
  output logic               carry_now
);
  localparam int PAD_W = PHASE_W - CTRL_W;

  logic [PHASE_W-1:0] audio_word;
  logic [CTRL_W-1:0]  ctrl_word;
  logic [PHASE_W-1:0] step;
  logic [PHASE_W:0]   sum;

  assign step      = range_sel ? {{PAD_W{1'b0}}, ctrl_word} : audio_word;
  assign sum       = {1'b0, phase} + {1'b0, step};
  assign carry_now = sample_en & sum[PHASE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      audio_word <= '0;
      ctrl_word  <= '0;
    end else if (tw_we) begin
      if (tw_sel) ctrl_word  <= tw_data[CTRL_W-1:0];
      else        audio_word <= tw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         phase <= '0;
    else if (sample_en) phase <= sum[PHASE_W-1:0];
  end

  // R9: phase only moves on a strobe
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(phase));
endmodule

// File: rtl/wt_bank_ctrl.sv
module wt_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic wrap,
  output logic active,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pending <= 1'b0;
    end else if (wrap && pending) begin
      active  <= ~active;
      pending <= 1'b0;
    end else if (swap_req) begin
      pending <= 1'b1;
    end
  end

  // R7: the playing bank changes only on a wrap with a swap pending
  p_swap_on_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> $past(wrap && pending));
  // R6: a pending swap survives until a wrap
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !wrap |=> pending);
  // R8: a wrap with nothing pending leaves the bank alone
  p_idle_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !pending |=> $stable(active));
endmodule

// File: rtl/wt_table_mem.sv
module wt_table_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_q [2];
  logic              sel_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == 1'(b)) store[wr_addr] <= wr_data;
      if (rd_en) bank_q[b] <= store[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) sel_q <= rd_bank;
  end

  assign rd_data = bank_q[sel_q];
endmodule

// File: rtl/wt_osc.sv
module wt_osc
  import wt_osc_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic          range_sel,
  input  logic          tw_we,
  input  logic          tw_sel,
  input  logic [PW-1:0] tw_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          swap_req,
  output logic          out_valid,
  output logic [DW-1:0] out_sample,
  output logic          play_bank
);
  logic [PW-1:0] phase;
  logic          carry_now;
  logic          pending;
  logic          strobe_q;
  logic          wr_fire;

  wt_phase_acc #(.PHASE_W(PW), .CTRL_W(CW)) u_acc (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .range_sel(range_sel),
    .tw_we(tw_we), .tw_sel(tw_sel), .tw_data(tw_data),
    .phase(phase), .carry_now(carry_now)
  );

  wt_bank_ctrl u_bank (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .wrap(carry_now),
    .active(play_bank), .pending(pending)
  );

  assign wr_ready = ~pending;
  assign wr_fire  = wr_valid & wr_ready;

  wt_table_mem #(.ADDR_W(AW), .DATA_W(DW)) u_mem (
    .clk(clk), .wr_en(wr_fire), .wr_bank(~play_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(strobe_q), .rd_bank(play_bank),
    .rd_addr(phase[PW-1 -: AW]), .rd_data(out_sample)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      strobe_q  <= sample_en;
      out_valid <= strobe_q;
    end
  end

  // R2: every output sample traces back to a strobe two edges earlier
  p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(sample_en, 2));
  // R6: the write stream is closed from a request until the swap
  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req && !carry_now |=> !wr_ready);
endmodule

// File: tb/wt_osc_tb.sv
module wt_osc_tb;
  localparam int PW = 48, AW = 11, DW = 16, CW = 28;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sample_en, range_sel, tw_we, tw_sel, wr_valid, swap_req;
  logic [PW-1:0] tw_data;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic wr_ready, out_valid, play_bank;
  logic [DW-1:0] out_sample;

  wt_osc u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .range_sel(range_sel),
    .tw_we(tw_we), .tw_sel(tw_sel), .tw_data(tw_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .swap_req(swap_req), .out_valid(out_valid), .out_sample(out_sample),
    .play_bank(play_bank)
  );

  int n_chk = 0, n_bad = 0;
  logic [PW-1:0] ph_m, aud_m;
  logic [CW-1:0] ctl_m;
  logic bank_m, pend_m;
  logic [DW-1:0] tab_m [2][DEPTH];
  bit known_m [2];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input bit which, input int a);
    return which ? DW'(16'hFFFF ^ (a * 5)) : DW'(a * 7 + 16'h1000);
  endfunction

  task automatic strobe();
    logic [PW:0] s;
    logic [AW-1:0] idx;
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
    check(out_valid === 1'b0, "R9 no sample after idle edge", out_valid, 0);
    s = {1'b0, ph_m} + {1'b0, (range_sel ? {{(PW-CW){1'b0}}, ctl_m} : aud_m)};
    ph_m = s[PW-1:0];
    if (s[PW] && pend_m) begin bank_m = ~bank_m; pend_m = 1'b0; end
    idx = ph_m[PW-1 -: AW];
    @(negedge clk);
    check(out_valid === 1'b1, "R2 out_valid after strobe", out_valid, 1);
    check(play_bank === bank_m, "R7/R8 play_bank", play_bank, bank_m);
    if (known_m[bank_m])
      check(out_sample === tab_m[bank_m][idx], "R2/R3 sample at index",
            out_sample, tab_m[bank_m][idx]);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  task automatic set_tw(input bit sel, input logic [PW-1:0] v);
    @(negedge clk) begin tw_we = 1'b1; tw_sel = sel; tw_data = v; end
    @(negedge clk) tw_we = 1'b0;
    if (sel) ctl_m = v[CW-1:0]; else aud_m = v;
  endtask

  // R5: load the bank that is not playing
  task automatic fill(input bit which);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk) begin
        wr_valid = 1'b1; wr_addr = AW'(a); wr_data = pat(which, a);
      end
      tab_m[~bank_m][a] = pat(which, a);
    end
    @(negedge clk) wr_valid = 1'b0;
    known_m[~bank_m] = 1'b1;
  endtask

  task automatic req_swap();
    @(negedge clk) swap_req = 1'b1;
    @(negedge clk) swap_req = 1'b0;
    pend_m = 1'b1;
    check(wr_ready === 1'b0, "R6 ready low while pending", wr_ready, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sample_en = 0; range_sel = 0; tw_we = 0; tw_sel = 0;
    tw_data = '0; wr_valid = 0; wr_addr = '0; wr_data = '0; swap_req = 0;
    ph_m = '0; aud_m = '0; ctl_m = '0; bank_m = 0; pend_m = 0;
    known_m[0] = 0; known_m[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid reset", out_valid, 0);
    check(play_bank === 1'b0, "R1 play_bank reset", play_bank, 0);
    check(wr_ready === 1'b1, "R1 wr_ready reset", wr_ready, 1);
  endtask

  task automatic t_first_swap();
    set_tw(1'b0, 48'h1 << 44);
    fill(1'b0);
    req_swap();
    // R6: beat offered while pending must be dropped
    @(negedge clk) begin wr_valid = 1'b1; wr_addr = AW'(256); wr_data = 16'hDEAD; end
    check(wr_ready === 1'b0, "R6 blocked beat", wr_ready, 0);
    @(negedge clk) wr_valid = 1'b0;
    run(20);
    check(wr_ready === 1'b1, "R7 ready back after swap", wr_ready, 1);
  endtask

  task automatic t_no_request();
    fill(1'b1);
    run(36);  // R8: two wraps with nothing pending
  endtask

  task automatic t_double_request();
    req_swap();
    req_swap();
    run(40);  // R8: exactly one toggle
    check(wr_ready === 1'b1, "R8 ready after double request", wr_ready, 1);
  endtask

  task automatic t_retune();
    run(5);
    set_tw(1'b0, (48'h3 << 40) + 48'd12345);  // R4
    run(50);
  endtask

  task automatic t_ctrl_range();
    set_tw(1'b1, {20'hABCDE, 28'hFFFFFFF});  // R4: upper bits ignored
    range_sel = 1'b1;                        // R3
    run(1200);
    range_sel = 1'b0;
    run(10);
  endtask

  initial begin
    t_reset();
    t_first_swap();
    t_no_request();
    t_double_request();
    t_retune();
    t_ctrl_range();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule